// File: doc/BRIEF.md
# Cascadable Reload Timer Bank

A set of five 16-bit down-counters that share one byte-wide register port. Each counter has a configuration byte, a 16-bit reload value written as two bytes, and a live count that can be read back as two bytes. A counter is loaded from its reload value and starts running in one of three ways: a software write, its own configuration byte (for the last counter only), or a transmit-end event when its start mode asks for that. While it runs, it decrements once per tick from its chosen source. That source can be one of two reference tick enables or the underflow of another counter in the bank, so counters can be chained to build longer intervals.

When a running counter is at zero and receives a tick, it underflows. It then raises its own bit on the underflow output for one cycle. After that it either reloads and keeps going or stops holding zero. A counter can also be told to stop as soon as the receiver reports its first four bits. Typical use is protocol supervision: a response timeout is armed at the end of a transmission and cancelled by the first received bits, and an interrupt controller collects the underflow pulses.

Top module: `timer_bank`

## Requirements
- R1: After synchronous reset every configuration byte, reload value and count reads 0, no counter runs, and `tmr_uf` is 0.
- R2: Address 0 is the shared start/stop register. Counter i occupies five consecutive addresses from 1+5*i, in this order: configuration, reload high byte, reload low byte, count high byte, count low byte. `rd_data` returns the byte at `rd_addr` one clock later.
- R3: A start loads the count from the reload value and sets the counter running. For counters 0 to 3 a start is a write to address 0 with bit i set. For counter 4 it is a configuration write with bit 2 set. Any counter whose start mode (configuration bits [5:4]) is 01 also starts on a `tx_end` pulse.
- R4: A running counter decrements by one on each tick of its source. A stopped counter holds its count. A reload value written while the counter runs is used only at the next load.
- R5: Configuration bits [1:0] pick the tick source of counter n: 00 `fast_tick`, 01 `slow_tick`, 10 an underflow of counter (n+1) mod 5, 11 an underflow of counter (n+2) mod 5. A cascaded tick is seen one cycle after the source's underflow pulse.
- R6: A tick that arrives while the count is 0 is an underflow. It drives bit n of `tmr_uf` high for exactly one cycle.
- R7: With auto-restart (configuration bit 3) set, an underflow reloads the count and the counter keeps running. With it clear, the counter stops and holds 0.
- R8: For counters 0 to 3, a write to address 0 with bit 4+i set stops counter i without changing its count. A stop wins over a start in the same cycle.
- R9: With configuration bit 7 set, an `rx_4bits` pulse stops the counter. With it clear, `rx_4bits` has no effect.
- R10: Start modes 10 and 11 are reserved: `tx_end` does not start such a counter.
- R11: Address 0 reads the run state of counters 0 to 3 in bits [3:0]. Counter 4's configuration byte reads its run state in bit 2. Bits 2 and 6 of the other configuration bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Registered read data |
| fast_tick | input | 1 | Fast reference tick enable (one cycle per tick) |
| slow_tick | input | 1 | Divided reference tick enable (one cycle per tick) |
| tx_end | input | 1 | One-cycle pulse at the end of a transmission |
| rx_4bits | input | 1 | One-cycle pulse after the first four received bits |
| tmr_uf | output | 5 | One-cycle underflow pulse, bit i for counter i |

## Verification
Assertions check the per-counter cycle rules on every clock:
- a start loads the reload value;
- a running counter steps down by exactly one per tick and a stopped one holds;
- an underflow pulse only follows a tick at zero;
- a one-shot counter ends stopped at zero;
- a stop always leaves the counter idle.

Only the directed scenarios show the things that depend on decode and routing: the address map, which source each select code reaches (including the wrap-around of the cascade partners), that reserved start modes and a cleared receive-stop bit ignore their events, and that a reload written mid-run waits for the next load.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  localparam int BYTE_W        = 8;
  localparam int CNT_W         = 2 * BYTE_W;
  localparam int REGS_PER_TMR  = 5;

  // per-timer register offsets from the timer's base address
  localparam int OFS_CFG    = 0;
  localparam int OFS_RLD_HI = 1;
  localparam int OFS_RLD_LO = 2;
  localparam int OFS_CNT_HI = 3;
  localparam int OFS_CNT_LO = 4;

  // configuration byte fields
  localparam int CFG_RX_HALT  = 7;
  localparam int CFG_MODE_HI  = 5;
  localparam int CFG_MODE_LO  = 4;
  localparam int CFG_AUTO     = 3;
  localparam int CFG_SELFRUN  = 2;
  localparam int CFG_SRC_HI   = 1;
  localparam int CFG_SRC_LO   = 0;

  // bits 6 and 2 are not stored
  localparam logic [BYTE_W-1:0] CFG_STORE_MASK = 8'hBB;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'b00,
    SRC_SLOW  = 2'b01,
    SRC_NEXT1 = 2'b10,
    SRC_NEXT2 = 2'b11
  } tick_src_e;

  typedef enum logic [1:0] {
    MODE_SOFT  = 2'b00,
    MODE_TXEND = 2'b01,
    MODE_RSV_A = 2'b10,
    MODE_RSV_B = 2'b11
  } start_mode_e;

endpackage

// File: rtl/timer_bank_tick_sel.sv
module timer_bank_tick_sel
  import timer_bank_pkg::*;
#(
  parameter int N_TMR = 5,
  parameter int IDX   = 0
) (
  input  tick_src_e          src,
  input  logic               fast_tick,
  input  logic               slow_tick,
  input  logic [N_TMR-1:0]   uf_q,
  output logic               tick
);

  localparam int PARTNER_A = (IDX + 1) % N_TMR;
  localparam int PARTNER_B = (IDX + 2) % N_TMR;

  always_comb begin
    unique case (src)
      SRC_FAST:  tick = fast_tick;
      SRC_SLOW:  tick = slow_tick;
      SRC_NEXT1: tick = uf_q[PARTNER_A];
      SRC_NEXT2: tick = uf_q[PARTNER_B];
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/timer_bank_chan.sv
module timer_bank_chan
  import timer_bank_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic          auto_rld,
  input  logic [W-1:0]  reload,
  output logic [W-1:0]  cnt,
  output logic          running,
  output logic          uf
);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      uf      <= 1'b0;
    end else begin
      uf <= 1'b0;
      if (stop) begin
        running <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        cnt     <= reload;
      end else if (running && tick) begin
        if (at_zero) begin
          uf <= 1'b1;
          if (auto_rld) cnt <= reload;
          else          running <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_load_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> (running && cnt == $past(reload)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !start && !stop && !at_zero) |=> (cnt == $past(cnt) - 1'b1));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!running && !start) |=> $stable(cnt));

  assert_uf_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    uf |-> ($past(cnt) == '0 && $past(running) && $past(tick)));

  assert_one_shot_end_R7: assert property (@(posedge clk) disable iff (rst)
    (uf && !$past(auto_rld)) |-> (!running && cnt == '0));

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (rst)
    stop |=> !running);

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int N_TMR  = 5,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [BYTE_W-1:0]     rd_data,
  input  logic                  fast_tick,
  input  logic                  slow_tick,
  input  logic                  tx_end,
  input  logic                  rx_4bits,
  output logic [N_TMR-1:0]      tmr_uf
);

  localparam int SW_N = N_TMR - 1;   // timers served by the shared register

  logic [N_TMR-1:0]             run_v;
  logic [N_TMR-1:0]             uf_v;
  logic [N_TMR-1:0][BYTE_W-1:0] cfg_view;
  logic [N_TMR-1:0][CNT_W-1:0]  rld_v;
  logic [N_TMR-1:0][CNT_W-1:0]  cnt_v;

  logic shared_wr;
  assign shared_wr = wr_en && (wr_addr == '0);

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    localparam int BASE = 1 + REGS_PER_TMR * i;

    logic [BYTE_W-1:0] cfg_r;
    logic [CNT_W-1:0]  rld_r;
    logic              sw_start, sw_stop;
    logic              start_ev, stop_ev, tick;
    logic              cfg_wr;

    assign cfg_wr = wr_en && (wr_addr == ADDR_W'(BASE + OFS_CFG));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_r <= '0;
        rld_r <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(BASE + OFS_CFG))
          cfg_r <= wr_data & CFG_STORE_MASK;
        if (wr_addr == ADDR_W'(BASE + OFS_RLD_HI))
          rld_r[CNT_W-1:BYTE_W] <= wr_data;
        if (wr_addr == ADDR_W'(BASE + OFS_RLD_LO))
          rld_r[BYTE_W-1:0] <= wr_data;
      end
    end

    if (i < SW_N) begin : g_shared_ctl
      assign sw_start = shared_wr && wr_data[i];
      assign sw_stop  = shared_wr && wr_data[SW_N + i];
      assign cfg_view[i] = cfg_r;
    end else begin : g_own_ctl
      assign sw_start = cfg_wr && wr_data[CFG_SELFRUN];
      assign sw_stop  = 1'b0;
      always_comb begin
        cfg_view[i] = cfg_r;
        cfg_view[i][CFG_SELFRUN] = run_v[i];
      end
    end

    assign start_ev = sw_start ||
      (start_mode_e'(cfg_r[CFG_MODE_HI:CFG_MODE_LO]) == MODE_TXEND && tx_end);
    assign stop_ev  = sw_stop || (cfg_r[CFG_RX_HALT] && rx_4bits);

    timer_bank_tick_sel #(.N_TMR(N_TMR), .IDX(i)) i_sel (
      .src       (tick_src_e'(cfg_r[CFG_SRC_HI:CFG_SRC_LO])),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .uf_q      (uf_v),
      .tick      (tick)
    );

    timer_bank_chan #(.W(CNT_W)) i_chan (
      .clk      (clk),
      .rst      (rst),
      .start    (start_ev),
      .stop     (stop_ev),
      .tick     (tick),
      .auto_rld (cfg_r[CFG_AUTO]),
      .reload   (rld_r),
      .cnt      (cnt_v[i]),
      .running  (run_v[i]),
      .uf       (uf_v[i])
    );

    assign rld_v[i] = rld_r;
  end

  assign tmr_uf = uf_v;

  logic [BYTE_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_addr == '0) rd_next = BYTE_W'(run_v[SW_N-1:0]);
    for (int i = 0; i < N_TMR; i++) begin
      if (rd_addr == ADDR_W'(1 + REGS_PER_TMR * i + OFS_CFG))    rd_next = cfg_view[i];
      if (rd_addr == ADDR_W'(1 + REGS_PER_TMR * i + OFS_RLD_HI)) rd_next = rld_v[i][CNT_W-1:BYTE_W];
      if (rd_addr == ADDR_W'(1 + REGS_PER_TMR * i + OFS_RLD_LO)) rd_next = rld_v[i][BYTE_W-1:0];
      if (rd_addr == ADDR_W'(1 + REGS_PER_TMR * i + OFS_CNT_HI)) rd_next = cnt_v[i][CNT_W-1:BYTE_W];
      if (rd_addr == ADDR_W'(1 + REGS_PER_TMR * i + OFS_CNT_LO)) rd_next = cnt_v[i][BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_uf_clear_in_reset_R1: assert property (@(posedge clk)
    rst |=> (tmr_uf == '0 && rd_data == '0));

endmodule

// File: tb/test_timer_bank.sv
module test_timer_bank;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       fast_tick, slow_tick, tx_end, rx_4bits;
  logic [4:0] tmr_uf;

  int total = 0;
  int bad   = 0;
  int ufc[5];

  always #5 clk = ~clk;

  timer_bank i_timer_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fast_tick(fast_tick),
    .slow_tick(slow_tick), .tx_end(tx_end), .rx_4bits(rx_4bits), .tmr_uf(tmr_uf)
  );

  always @(negedge clk) begin
    if (!rst) for (int i = 0; i < 5; i++) if (tmr_uf[i]) ufc[i]++;
  end

  function automatic logic [4:0] ad(input int t, input int ofs);
    return 5'(1 + 5 * t + ofs);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    fast_tick = 1'b0; slow_tick = 1'b0; tx_end = 1'b0; rx_4bits = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) ufc[i] = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic rd_cnt(input int t, output int v);
    int hi, lo;
    rd(ad(t, 3), hi);
    rd(ad(t, 4), lo);
    v = (hi << 8) | lo;
  endtask

  task automatic set_reload(input int t, input int val);
    wr(ad(t, 1), 8'(val >> 8));
    wr(ad(t, 2), 8'(val));
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_fast(input int n);
    repeat (n) begin fast_tick = 1'b1; @(posedge clk); @(negedge clk); fast_tick = 1'b0; end
  endtask

  task automatic pulse_slow(input int n);
    repeat (n) begin slow_tick = 1'b1; @(posedge clk); @(negedge clk); slow_tick = 1'b0; end
  endtask

  task automatic pulse_tx();
    tx_end = 1'b1; @(posedge clk); @(negedge clk); tx_end = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_4bits = 1'b1; @(posedge clk); @(negedge clk); rx_4bits = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(5'd0, v);        chk("R1", "shared reg after reset", v, 0);
    rd_cnt(0, v);       chk("R1", "timer0 count after reset", v, 0);
    rd(ad(2, 2), v);    chk("R1", "timer2 reload lo after reset", v, 0);
    rd(ad(4, 0), v);    chk("R1", "timer4 cfg after reset", v, 0);
    chk("R1", "no underflow after reset", ufc[0] + ufc[1] + ufc[2] + ufc[3] + ufc[4], 0);
  endtask

  task automatic t_start_count();
    int v;
    do_reset();
    set_reload(0, 16'h0105);
    rd(ad(0, 1), v);    chk("R2", "timer0 reload hi readback", v, 8'h01);
    wr(5'd0, 8'h01);
    rd_cnt(0, v);       chk("R3", "sw start loads reload", v, 16'h0105);
    rd(5'd0, v);        chk("R11", "timer0 run flag", v, 8'h01);
    pulse_fast(3);
    rd_cnt(0, v);       chk("R4", "three fast ticks", v, 16'h0102);
  endtask

  task automatic t_slow_src();
    int v;
    do_reset();
    set_reload(1, 10);
    wr(ad(1, 0), 8'h01);
    wr(5'd0, 8'h02);
    pulse_fast(4);
    rd_cnt(1, v);       chk("R5", "slow source ignores fast ticks", v, 10);
    pulse_slow(2);
    rd_cnt(1, v);       chk("R5", "slow source counts slow ticks", v, 8);
  endtask

  task automatic t_one_shot();
    int v;
    do_reset();
    set_reload(2, 2);
    wr(5'd0, 8'h04);
    pulse_fast(2);
    rd_cnt(2, v);       chk("R4", "one-shot reaches zero", v, 0);
    chk("R6", "no underflow before tick at zero", ufc[2], 0);
    pulse_fast(1);
    rd_cnt(2, v);       chk("R7", "one-shot holds zero", v, 0);
    chk("R6", "single underflow pulse", ufc[2], 1);
    rd(5'd0, v);        chk("R7", "one-shot stopped", v, 0);
    pulse_fast(3);
    rd_cnt(2, v);       chk("R7", "stopped stays zero", v, 0);
    chk("R6", "no more underflows when stopped", ufc[2], 1);
  endtask

  task automatic t_auto_restart();
    int v;
    do_reset();
    set_reload(3, 1);
    wr(ad(3, 0), 8'h08);
    wr(5'd0, 8'h08);
    pulse_fast(4);
    rd_cnt(3, v);       chk("R7", "auto restart reloaded", v, 1);
    chk("R6", "two underflows", ufc[3], 2);
    rd(5'd0, v);        chk("R7", "auto restart keeps running", v, 8'h08);
  endtask

  task automatic t_sw_stop();
    int v;
    do_reset();
    set_reload(0, 9);
    wr(5'd0, 8'h01);
    pulse_fast(2);
    wr(5'd0, 8'h10);
    pulse_fast(3);
    rd_cnt(0, v);       chk("R8", "stopped count held", v, 7);
    rd(5'd0, v);        chk("R8", "stop clears run flag", v, 0);
    wr(5'd0, 8'h11);
    rd(5'd0, v);        chk("R8", "stop wins over start", v, 0);
    rd_cnt(0, v);       chk("R8", "no load when stop wins", v, 7);
  endtask

  task automatic t_tx_start();
    int v;
    do_reset();
    set_reload(4, 5);
    wr(ad(4, 0), 8'h10);
    set_reload(2, 7);
    wr(ad(2, 0), 8'h20);
    set_reload(1, 7);
    wr(ad(1, 0), 8'h30);
    pulse_tx();
    rd_cnt(4, v);       chk("R3", "tx_end start loads timer4", v, 5);
    rd(ad(4, 0), v);    chk("R11", "timer4 cfg shows run bit", v, 8'h14);
    rd_cnt(2, v);       chk("R10", "mode 10 ignores tx_end", v, 0);
    rd(5'd0, v);        chk("R10", "reserved modes not running", v, 0);
    rd(ad(2, 0), v);    chk("R11", "timer2 cfg readback", v, 8'h20);
  endtask

  task automatic t_rx_stop();
    int v;
    do_reset();
    set_reload(4, 16'h20);
    wr(ad(4, 0), 8'h84);
    set_reload(0, 16'h20);
    wr(5'd0, 8'h01);
    pulse_fast(1);
    pulse_rx();
    pulse_fast(2);
    rd_cnt(4, v);       chk("R9", "rx stop halts timer4", v, 16'h1f);
    rd(ad(4, 0), v);    chk("R9", "timer4 not running", v, 8'h80);
    rd_cnt(0, v);       chk("R9", "cleared halt bit ignores rx", v, 16'h1d);
  endtask

  task automatic t_cascade();
    int v;
    do_reset();
    set_reload(1, 0);
    wr(ad(1, 0), 8'h08);
    set_reload(0, 2);
    wr(ad(0, 0), 8'h02);
    set_reload(4, 3);
    wr(ad(4, 0), 8'h07);
    wr(5'd0, 8'h03);
    pulse_fast(2);
    idle(2);
    chk("R5", "source timer1 underflows", ufc[1], 2);
    rd_cnt(0, v);       chk("R5", "timer0 ticked by timer1", v, 0);
    rd_cnt(4, v);       chk("R5", "timer4 wraps to timer1", v, 1);
    pulse_fast(1);
    idle(2);
    chk("R6", "timer0 cascaded underflow", ufc[0], 1);
    rd_cnt(4, v);       chk("R5", "timer4 third cascade tick", v, 0);
    chk("R6", "timer4 no underflow yet", ufc[4], 0);
  endtask

  task automatic t_live_reload();
    int v;
    do_reset();
    set_reload(0, 4);
    wr(ad(0, 0), 8'h08);
    wr(5'd0, 8'h01);
    wr(ad(0, 2), 8'h09);
    pulse_fast(1);
    rd_cnt(0, v);       chk("R4", "live reload not applied", v, 3);
    pulse_fast(4);
    rd_cnt(0, v);       chk("R7", "new reload used at underflow", v, 9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_start_count();
    t_slow_src();
    t_one_shot();
    t_auto_restart();
    t_sw_stop();
    t_tx_start();
    t_rx_stop();
    t_cascade();
    t_live_reload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule